// File: doc/BRIEF.md
# Multi-Domain Idle Wake-Up Controller

This block decides which clock domains of a subsystem may run while the system sits idle. It watches a set of wake sources: an active-low processor interrupt, a coprocessor interrupt with the coprocessor's idle acknowledge, an external interconnect-enable pin, and two DMA request lines. One DMA line comes from the traffic controller and the other from the peripheral bridge. Each source turns on its own fixed group of domain clock enables. All sources run through two-flop synchronizers before the block decodes them.

Any wake first raises a PLL wake request. No domain enable rises until the synchronized PLL-locked input is high. Every source except the coprocessor interrupt is level-held: its domains run only while that source stays asserted. The coprocessor wake is latched and held until that core reports that it has left idle.

Two 32-bit idle-control registers pick which peripheral clocks follow a processor wake and which follow a coprocessor wake. A read-only status register shows the synchronized wake sources.

Top module: `idle_wake_ctrl`

## Requirements
- R1: After reset, `clk_en`, `per_en`, `pll_wake` and `dsp_wake_req` are all 0, and both idle-control registers read 0.
- R2: Idle-control register A is at address 0x0 and register B is at 0x4. Both hold all 32 written bits and read them back on `bus_rdata`. Address 0x8 is a read-only status word: a write to it changes nothing. Any other address reads 0.
- R3: While `proc_irq_n` is low and the PLL is locked, `clk_en` bits 0 (processor core), 1 (processor interrupt controller), 2 (peripheral bridge), 3 (DMA) and 4 (traffic controller) are 1. Over the same interval, `per_en` bit i is 1 wherever bit i of register A is 1.
- R4: While the coprocessor wake is active and the PLL is locked, `clk_en` bits 8 (coprocessor core), 9 (coprocessor interrupt controller) and 4 are 1. Over the same interval, `per_en` bit i is 1 wherever bit i of register B is 1.
- R5: A high `dsp_irq` sets `dsp_wake_req`. Once set, `dsp_wake_req` stays 1 while `dsp_idle` is high, even after `dsp_irq` falls. It clears only when `dsp_irq` is low and `dsp_idle` is low.
- R6: While `icn_en` is high and the PLL is locked, `clk_en` bits 4, 5, 6 (secondary traffic-controller clocks) and 7 (interconnect) are 1. Bits 5 to 7 have no other source.
- R7: While `tc_dma_req` is high and the PLL is locked, `clk_en` bits 3 and 4 are 1.
- R8: While `br_dma_req` is high and the PLL is locked, `clk_en` bits 2, 3 and 4 are 1.
- R9: `pll_wake` is 1 whenever any source is active. While the synchronized `pll_locked` is 0, every bit of `clk_en` and `per_en` is 0.
- R10: Every enable equals the OR of the current requests. When a level-held input falls, its bits drop on the third rising edge after the change, unless another source still needs them. A change of wake source never alters the idle-control registers.
- R11: The status word at 0x8 holds the synchronized sources in these bits: bit 0 processor, bit 1 `dsp_wake_req`, bit 2 interconnect pin, bit 3 traffic-controller DMA, bit 4 bridge DMA, bit 5 `pll_wake`. Bits 31 to 6 are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| proc_irq_n | input | 1 | Processor interrupt request, active low, asynchronous |
| dsp_irq | input | 1 | Coprocessor interrupt request, asynchronous |
| dsp_idle | input | 1 | Coprocessor idle acknowledge, high while idle |
| icn_en | input | 1 | External interconnect-enable pin |
| tc_dma_req | input | 1 | DMA request from the traffic controller |
| br_dma_req | input | 1 | DMA request from the peripheral bridge |
| pll_locked | input | 1 | PLL lock indication |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | AW | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational on `bus_addr` |
| clk_en | output | 10 | Domain clock enables, bit map as in R3 to R8 |
| per_en | output | NPER | Peripheral clock enables |
| pll_wake | output | 1 | PLL wake request |
| dsp_wake_req | output | 1 | Held coprocessor wake request |

## Verification
The assertions assume that every asynchronous input holds a level for several cycles, so the synchronizers never miss a pulse. They also assume that `bus_wr` is a single-cycle strobe, sampled like any other synchronous input. The bench meets both assumptions: it changes inputs only on falling clock edges, and it waits at least five cycles before it compares enables. The one exception is the drop-timing test, which samples on exact cycles. When `dsp_idle` is held low, the coprocessor latch follows `dsp_irq`. This lets the bench sweep every combination of the five wake levels and the lock input against an arithmetic model, and it tests the hold behaviour on its own.

// File: rtl/idle_wake_ctrl.sv
module idle_wake_ctrl #(
  parameter int NPER = 8,
  parameter int AW   = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            proc_irq_n,
  input  logic            dsp_irq,
  input  logic            dsp_idle,
  input  logic            icn_en,
  input  logic            tc_dma_req,
  input  logic            br_dma_req,
  input  logic            pll_locked,
  input  logic            bus_wr,
  input  logic [AW-1:0]   bus_addr,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  output logic [9:0]      clk_en,
  output logic [NPER-1:0] per_en,
  output logic            pll_wake,
  output logic            dsp_wake_req
);
  localparam int NS = 7;
  localparam logic [AW-1:0] A_CTLA = AW'(0);
  localparam logic [AW-1:0] A_CTLB = AW'(4);
  localparam logic [AW-1:0] A_STAT = AW'(8);

  logic [NS-1:0] raw, sy1, sy2;
  logic [31:0]   ctla, ctlb;
  logic          dsp_lat;
  logic [9:0]    need;
  logic [NPER-1:0] per_need;
  logic          any_wake;

  assign raw = {pll_locked, br_dma_req, tc_dma_req, icn_en, dsp_idle, dsp_irq, ~proc_irq_n};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sy1 <= '0;
      sy2 <= '0;
    end else begin
      sy1 <= raw;
      sy2 <= sy1;
    end

  wire s_cpu  = sy2[0];
  wire s_dirq = sy2[1];
  wire s_didl = sy2[2];
  wire s_icn  = sy2[3];
  wire s_tcd  = sy2[4];
  wire s_brd  = sy2[5];
  wire s_lock = sy2[6];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          dsp_lat <= 1'b0;
    else if (s_dirq)     dsp_lat <= 1'b1;
    else if (!s_didl)    dsp_lat <= 1'b0;

  assign dsp_wake_req = dsp_lat;

  assign need[0] = s_cpu;
  assign need[1] = s_cpu;
  assign need[2] = s_cpu | s_brd;
  assign need[3] = s_cpu | s_tcd | s_brd;
  assign need[4] = s_cpu | dsp_lat | s_icn | s_tcd | s_brd;
  assign need[5] = s_icn;
  assign need[6] = s_icn;
  assign need[7] = s_icn;
  assign need[8] = dsp_lat;
  assign need[9] = dsp_lat;

  assign per_need = (s_cpu   ? ctla[NPER-1:0] : '0)
                  | (dsp_lat ? ctlb[NPER-1:0] : '0);

  assign any_wake = s_cpu | s_dirq | dsp_lat | s_icn | s_tcd | s_brd;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      clk_en   <= '0;
      per_en   <= '0;
      pll_wake <= 1'b0;
    end else begin
      clk_en   <= s_lock ? need : '0;
      per_en   <= s_lock ? per_need : '0;
      pll_wake <= any_wake;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ctla <= '0;
      ctlb <= '0;
    end else if (bus_wr) begin
      if (bus_addr == A_CTLA) ctla <= bus_wdata;
      if (bus_addr == A_CTLB) ctlb <= bus_wdata;
    end

  always_comb begin
    case (bus_addr)
      A_CTLA:  bus_rdata = ctla;
      A_CTLB:  bus_rdata = ctlb;
      A_STAT:  bus_rdata = {26'b0, pll_wake, s_brd, s_tcd, s_icn, dsp_lat, s_cpu};
      default: bus_rdata = '0;
    endcase
  end

  AST_EN_NEEDS_PLL: assert property (@(posedge clk) disable iff (!rst_n)
    (|clk_en || |per_en) |-> pll_wake);  // R9
  AST_DSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (dsp_wake_req && s_didl) |=> dsp_wake_req);  // R5
  AST_CPU_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en[0] |-> (&clk_en[4:0]));  // R3
  AST_DSP_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en[8] |-> (clk_en[9] && clk_en[4]));  // R4
  AST_ICN_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en[7] |-> (clk_en[6] && clk_en[5] && clk_en[4]));  // R6
  AST_PER_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (|per_en) |-> (clk_en[0] || clk_en[8]));  // R3
  AST_CTL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> ($stable(ctla) && $stable(ctlb)));  // R10
endmodule

// File: tb/sim_idle_wake_ctrl.sv
module sim_idle_wake_ctrl;
  localparam int NPER = 8;
  localparam int AW   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic proc_irq_n = 1'b1, dsp_irq = 1'b0, dsp_idle = 1'b0, icn_en = 1'b0;
  logic tc_dma_req = 1'b0, br_dma_req = 1'b0, pll_locked = 1'b0;
  logic bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [9:0] clk_en;
  logic [NPER-1:0] per_en;
  logic pll_wake, dsp_wake_req;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  idle_wake_ctrl #(.NPER(NPER), .AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .proc_irq_n(proc_irq_n), .dsp_irq(dsp_irq),
    .dsp_idle(dsp_idle), .icn_en(icn_en), .tc_dma_req(tc_dma_req),
    .br_dma_req(br_dma_req), .pll_locked(pll_locked), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .clk_en(clk_en), .per_en(per_en), .pll_wake(pll_wake), .dsp_wake_req(dsp_wake_req));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_neg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  function automatic logic [9:0] exp_dom(input bit c, input bit d, input bit i,
                                         input bit t, input bit b, input bit l);
    logic [9:0] v;
    v = '0;
    if (c) v = v | 10'b00_0001_1111;
    if (d) v = v | 10'b11_0001_0000;
    if (i) v = v | 10'b00_1111_0000;
    if (t) v = v | 10'b00_0001_1000;
    if (b) v = v | 10'b00_0001_1100;
    return l ? v : '0;
  endfunction

  initial begin
    #(4 * 150000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] rv;
    logic [31:0] ca, cb;
    wait_neg(3);
    // R1 reset state
    chk("R1 clk_en", clk_en, 0);
    chk("R1 per_en", per_en, 0);
    chk("R1 pll_wake", pll_wake, 0);
    chk("R1 dsp_wake_req", dsp_wake_req, 0);
    rst_n = 1'b1;
    wait_neg(2);
    rd(AW'(0), rv); chk("R1 ctlA", rv, 0);
    rd(AW'(4), rv); chk("R1 ctlB", rv, 0);

    // R2 register map
    wr(AW'(0), 32'hDEAD_BEA5);
    wr(AW'(4), 32'h1234_563C);
    wr(AW'(8), 32'hFFFF_FFFF);
    rd(AW'(0), rv); chk("R2 ctlA readback", rv, 32'hDEAD_BEA5);
    rd(AW'(4), rv); chk("R2 ctlB readback", rv, 32'h1234_563C);
    rd(AW'(8), rv); chk("R2 status unaffected by write", rv, 0);
    rd(AW'(12), rv); chk("R2 unmapped reads 0", rv, 0);

    // R3 R4 R6 R7 R8 R9 R11 sweep
    for (int cfg = 0; cfg < 2; cfg++) begin
      ca = (cfg == 0) ? 32'hDEAD_BEA5 : 32'h0000_00F0;
      cb = (cfg == 0) ? 32'h1234_563C : 32'hFFFF_FF0F;
      if (cfg == 1) begin
        wr(AW'(0), ca);
        wr(AW'(4), cb);
      end
      for (int v = 0; v < 64; v++) begin
        logic [9:0] ed;
        logic [NPER-1:0] ep;
        bit c, d, i, t, b, l, any;
        c = v[0]; d = v[1]; i = v[2]; t = v[3]; b = v[4]; l = v[5];
        @(negedge clk);
        proc_irq_n = ~c; dsp_irq = d; dsp_idle = 1'b0; icn_en = i;
        tc_dma_req = t; br_dma_req = b; pll_locked = l;
        wait_neg(6);
        ed = exp_dom(c, d, i, t, b, l);
        ep = l ? ((c ? ca[NPER-1:0] : '0) | (d ? cb[NPER-1:0] : '0)) : '0;
        any = c | d | i | t | b;
        chk("R3/R4/R6/R7/R8/R9 clk_en", clk_en, ed);
        chk("R3/R4/R9 per_en", per_en, ep);
        chk("R9 pll_wake", pll_wake, any);
        rd(AW'(8), rv);
        chk("R11 status", rv, {26'b0, any, b, t, i, d, c});
      end
    end
    rd(AW'(0), rv); chk("R10 ctlA unchanged by sources", rv, ca);
    rd(AW'(4), rv); chk("R10 ctlB unchanged by sources", rv, cb);

    // R10 drop timing with icn only
    @(negedge clk);
    proc_irq_n = 1'b1; dsp_irq = 1'b0; icn_en = 1'b1; tc_dma_req = 1'b0;
    br_dma_req = 1'b0; pll_locked = 1'b1;
    wait_neg(6);
    chk("R6 icn on", clk_en, 10'b00_1111_0000);
    icn_en = 1'b0;
    wait_neg(2);
    chk("R10 still on two edges after drop", clk_en, 10'b00_1111_0000);
    wait_neg(1);
    chk("R10 off on third edge", clk_en, 0);

    // R10 overlap: icn falls while tc dma holds bit 3/4
    icn_en = 1'b1; tc_dma_req = 1'b1;
    wait_neg(6);
    icn_en = 1'b0;
    wait_neg(4);
    chk("R10 shared bits kept by tc dma", clk_en, 10'b00_0001_1000);
    tc_dma_req = 1'b0;
    wait_neg(4);

    // R5 coprocessor hold
    dsp_idle = 1'b1; dsp_irq = 1'b1;
    wait_neg(6);
    chk("R5 wake req set", dsp_wake_req, 1);
    dsp_irq = 1'b0;
    wait_neg(8);
    chk("R5 held while idle", dsp_wake_req, 1);
    chk("R4 domains held", clk_en, 10'b11_0001_0000);
    chk("R4 per_en held", per_en, cb[NPER-1:0]);
    dsp_idle = 1'b0;
    wait_neg(6);
    chk("R5 cleared after idle low", dsp_wake_req, 0);
    chk("R5 domains released", clk_en, 0);

    // R9 lock loss gates everything
    proc_irq_n = 1'b0;
    wait_neg(6);
    pll_locked = 1'b0;
    wait_neg(6);
    chk("R9 gated without lock", clk_en, 0);
    chk("R9 pll_wake kept", pll_wake, 1);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule